// File: doc/BRIEF.md
# DMA Channel Request Enable Gating

This block keeps two enable bits for every channel of a multi-channel DMA engine. One bit lets the channel's hardware request line through. The other lets the channel's error indicator raise an interrupt. There are 32 channels by default, and every bit starts at zero.

Software can change the bits in three ways. It can write a whole word of enables over the register bus. It can set the bit of one channel through a set port. It can clear the bit of one channel through a clear port. Both the set port and the clear port take a channel number, so no read-modify-write is needed. The request enables have one more path: when a channel finishes its major loop and its disable-on-done flag is 1, the engine clears that channel's request enable.

The gating is purely combinational. A hardware request passes only when its enable bit is 1. A software-initiated or linked request for a channel always passes. An error indicator passes only when its error enable bit is 1. The arbiter and the interrupt controller take these qualified outputs.

Top module: `dma_chan_gate`

## Requirements
- R1: After reset, every request-enable bit and every error-enable bit is 0. Both register words read 0, no hardware request passes, and no error interrupt is raised.
- R2: A bus write to offset 0x0C loads the request-enable word, and a bus write to offset 0x10 loads the error-enable word. In both words, bit i holds channel NUM_CH-1-i, so bit 0 holds channel 31. A read returns the current word in the same bit order, and a read of any other offset returns 0.
- R3: A channel's service output for a hardware request is high only when that channel's hardware request input and its request-enable bit are both 1.
- R4: A software-initiated or linked request for a channel drives that channel's service output high in the same cycle, whatever the state of its request-enable bit.
- R5: A valid set or clear of the request enable for channel c changes only bit c, to 1 or to 0, at the next rising clock edge.
- R6: A valid set or clear of the error enable for channel c changes only bit c, to 1 or to 0, at the next rising clock edge.
- R7: A major-loop-done event for channel c with its flag at 1 clears request-enable bit c at the next edge. With the flag at 0, the event leaves every bit unchanged.
- R8: A channel's error interrupt output is high only when that channel's error indicator and its error-enable bit are both 1.
- R9: Several updates can hit the same bit in one cycle. The done-clear wins over a single-channel clear. A single-channel clear wins over a single-channel set. A single-channel set wins over a full-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus word write strobe |
| bus_addr | input | 8 | Bus byte offset for reads and writes |
| bus_wdata | input | 32 | Bus write word, with channel 31 in bit 0 |
| bus_rdata | output | 32 | Bus read word for bus_addr, in the same order as bus_wdata |
| req_set_vld | input | 1 | Set the request enable of one channel |
| req_set_ch | input | 5 | Channel for req_set_vld |
| req_clr_vld | input | 1 | Clear the request enable of one channel |
| req_clr_ch | input | 5 | Channel for req_clr_vld |
| err_set_vld | input | 1 | Set the error enable of one channel |
| err_set_ch | input | 5 | Channel for err_set_vld |
| err_clr_vld | input | 1 | Clear the error enable of one channel |
| err_clr_ch | input | 5 | Channel for err_clr_vld |
| done_vld | input | 1 | Major-loop-done event |
| done_ch | input | 5 | Channel that finished its major loop |
| done_dis | input | 1 | Disable-on-done flag of the finishing channel |
| hw_req_i | input | 32 | Hardware request lines, indexed by channel |
| sw_req_i | input | 32 | Software-initiated requests, indexed by channel |
| link_req_i | input | 32 | Linked-channel requests, indexed by channel |
| err_ind_i | input | 32 | Error indicators, indexed by channel |
| svc_req_o | output | 32 | Qualified service requests, indexed by channel |
| err_irq_o | output | 32 | Qualified error interrupts, indexed by channel |

## Verification
A word write, a set, a clear or a done event takes effect on the rising edge after the cycle in which it is presented. The gated outputs and the read word then show the new bit right after that edge, with no further delay. The gated outputs and the read word are combinational in their inputs and give their result in the same cycle. The bench therefore drives every input on a falling edge. It checks an update at the following falling edge, one register stage later. It checks a purely combinational result a short delay after the inputs settle, with no clock in between.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int DCG_NUM_CH  = 32;
    localparam int DCG_ADDR_W  = 8;

    // Which enable word a bus offset selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_REQ  = 2'd1,
        SEL_ERR  = 2'd2
    } dcg_sel_e;

endpackage

// File: rtl/dcg_en_bank.sv
// One bank of per-channel enable bits. It takes a full-word load, a single-channel
// set, a single-channel clear and, optionally, a done-clear. Later assignments in
// the next-value logic win, which gives the priority done > clear > set > word.
module dcg_en_bank #(
    parameter int NUM_CH   = 32,
    parameter int CH_W     = 5,
    parameter bit HAS_DONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic              set_vld,
    input  logic [CH_W-1:0]   set_ch,
    input  logic              clr_vld,
    input  logic [CH_W-1:0]   clr_ch,
    input  logic              done_vld,
    input  logic [CH_W-1:0]   done_ch,
    input  logic              done_flag,
    output logic [NUM_CH-1:0] en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_vld) begin
            bank_d.en = wr_data;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (set_vld && (set_ch == CH_W'(i))) begin
                bank_d.en[i] = 1'b1;
            end
            if (clr_vld && (clr_ch == CH_W'(i))) begin
                bank_d.en[i] = 1'b0;
            end
            if (HAS_DONE && done_vld && done_flag && (done_ch == CH_W'(i))) begin
                bank_d.en[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_o = bank_q.en;

endmodule

// File: rtl/dcg_gate.sv
// Combinational qualification of requests and error indicators.
module dcg_gate #(
    parameter int NUM_CH = 32
) (
    input  logic [NUM_CH-1:0] req_en,
    input  logic [NUM_CH-1:0] err_en,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] link_req,
    input  logic [NUM_CH-1:0] err_ind,
    output logic [NUM_CH-1:0] svc_req,
    output logic [NUM_CH-1:0] err_irq
);

    logic [NUM_CH-1:0] hw_ok;
    logic [NUM_CH-1:0] bypass;

    always_comb begin
        hw_ok   = hw_req & req_en;
        bypass  = sw_req | link_req;
        svc_req = hw_ok | bypass;
        err_irq = err_ind & err_en;
    end

endmodule

// File: rtl/dcg_rd_mux.sv
// Bus read path: decodes the offset and returns the selected bank,
// with channel NUM_CH-1 placed in bit 0.
module dcg_rd_mux
    import dcg_pkg::*;
#(
    parameter int                NUM_CH  = 32,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REQ_OFS = 8'h0C,
    parameter logic [ADDR_W-1:0] ERR_OFS = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] req_en,
    input  logic [NUM_CH-1:0] err_en,
    output logic [NUM_CH-1:0] rdata
);

    dcg_sel_e          sel;
    logic [NUM_CH-1:0] chan_word;

    always_comb begin
        if (addr == REQ_OFS) begin
            sel = SEL_REQ;
        end else if (addr == ERR_OFS) begin
            sel = SEL_ERR;
        end else begin
            sel = SEL_NONE;
        end
        case (sel)
            SEL_REQ: chan_word = req_en;
            SEL_ERR: chan_word = err_en;
            default: chan_word = '0;
        endcase
    end

    for (genvar b = 0; b < NUM_CH; b++) begin : g_rev
        assign rdata[b] = chan_word[NUM_CH-1-b];
    end

endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
    import dcg_pkg::*;
#(
    parameter int                NUM_CH  = DCG_NUM_CH,
    parameter int                CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int                ADDR_W  = DCG_ADDR_W,
    parameter logic [ADDR_W-1:0] REQ_OFS = 8'h0C,
    parameter logic [ADDR_W-1:0] ERR_OFS = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    input  logic              req_set_vld,
    input  logic [CH_W-1:0]   req_set_ch,
    input  logic              req_clr_vld,
    input  logic [CH_W-1:0]   req_clr_ch,
    input  logic              err_set_vld,
    input  logic [CH_W-1:0]   err_set_ch,
    input  logic              err_clr_vld,
    input  logic [CH_W-1:0]   err_clr_ch,
    input  logic              done_vld,
    input  logic [CH_W-1:0]   done_ch,
    input  logic              done_dis,
    input  logic [NUM_CH-1:0] hw_req_i,
    input  logic [NUM_CH-1:0] sw_req_i,
    input  logic [NUM_CH-1:0] link_req_i,
    input  logic [NUM_CH-1:0] err_ind_i,
    output logic [NUM_CH-1:0] svc_req_o,
    output logic [NUM_CH-1:0] err_irq_o
);

    localparam logic [CH_W-1:0] CH_ZERO = '0;

    logic              wr_req_word;
    logic              wr_err_word;
    logic [NUM_CH-1:0] wr_chan;
    logic [NUM_CH-1:0] req_en_q;
    logic [NUM_CH-1:0] err_en_q;

    assign wr_req_word = bus_wr && (bus_addr == REQ_OFS);
    assign wr_err_word = bus_wr && (bus_addr == ERR_OFS);

    for (genvar b = 0; b < NUM_CH; b++) begin : g_wrev
        assign wr_chan[b] = bus_wdata[NUM_CH-1-b];
    end

    dcg_en_bank #(
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W),
        .HAS_DONE (1'b1)
    ) req_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_req_word),
        .wr_data   (wr_chan),
        .set_vld   (req_set_vld),
        .set_ch    (req_set_ch),
        .clr_vld   (req_clr_vld),
        .clr_ch    (req_clr_ch),
        .done_vld  (done_vld),
        .done_ch   (done_ch),
        .done_flag (done_dis),
        .en_o      (req_en_q)
    );

    dcg_en_bank #(
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W),
        .HAS_DONE (1'b0)
    ) err_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_err_word),
        .wr_data   (wr_chan),
        .set_vld   (err_set_vld),
        .set_ch    (err_set_ch),
        .clr_vld   (err_clr_vld),
        .clr_ch    (err_clr_ch),
        .done_vld  (1'b0),
        .done_ch   (CH_ZERO),
        .done_flag (1'b0),
        .en_o      (err_en_q)
    );

    dcg_gate #(
        .NUM_CH (NUM_CH)
    ) gate_i (
        .req_en   (req_en_q),
        .err_en   (err_en_q),
        .hw_req   (hw_req_i),
        .sw_req   (sw_req_i),
        .link_req (link_req_i),
        .err_ind  (err_ind_i),
        .svc_req  (svc_req_o),
        .err_irq  (err_irq_o)
    );

    dcg_rd_mux #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .REQ_OFS (REQ_OFS),
        .ERR_OFS (ERR_OFS)
    ) rd_mux_i (
        .addr   (bus_addr),
        .req_en (req_en_q),
        .err_en (err_en_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/dma_chan_gate_chk.sv
module dma_chan_gate_chk #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              req_set_vld,
    input logic [CH_W-1:0]   req_set_ch,
    input logic              req_clr_vld,
    input logic [CH_W-1:0]   req_clr_ch,
    input logic              err_set_vld,
    input logic [CH_W-1:0]   err_set_ch,
    input logic              err_clr_vld,
    input logic [CH_W-1:0]   err_clr_ch,
    input logic              done_vld,
    input logic [CH_W-1:0]   done_ch,
    input logic              done_dis,
    input logic [NUM_CH-1:0] hw_req_i,
    input logic [NUM_CH-1:0] sw_req_i,
    input logic [NUM_CH-1:0] link_req_i,
    input logic [NUM_CH-1:0] err_ind_i,
    input logic [NUM_CH-1:0] svc_req_o,
    input logic [NUM_CH-1:0] err_irq_o,
    input logic [NUM_CH-1:0] req_en,
    input logic [NUM_CH-1:0] err_en
);

    // R3, R4: a service request needs a hardware, software or linked source
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_svc_has_source_R3: assert ((svc_req_o & ~(hw_req_i | sw_req_i | link_req_i)) == '0)
                else $error("service request with no source");
            assert_bypass_passes_R4: assert (((sw_req_i | link_req_i) & ~svc_req_o) == '0)
                else $error("software or linked request blocked");
            assert_irq_needs_ind_R8: assert ((err_irq_o & ~err_ind_i) == '0)
                else $error("interrupt without error indicator");
        end
    end

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_dis) |=> !req_en[$past(done_ch)])
        else $error("done-clear did not clear enable");

    assert_done_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !done_dis && !bus_wr && !req_set_vld && !req_clr_vld) |=> (req_en == $past(req_en)))
        else $error("done with flag low changed enables");

    assert_req_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_clr_vld |=> !req_en[$past(req_clr_ch)])
        else $error("request clear failed");

    assert_req_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set_vld && !(req_clr_vld && req_clr_ch == req_set_ch)
         && !(done_vld && done_dis && done_ch == req_set_ch)) |=> req_en[$past(req_set_ch)])
        else $error("request set failed");

    assert_err_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_vld |=> !err_en[$past(err_clr_ch)])
        else $error("error clear failed");

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set_vld && !(err_clr_vld && err_clr_ch == err_set_ch)) |=> err_en[$past(err_set_ch)])
        else $error("error set failed");

    assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !err_set_vld && !err_clr_vld) |=> $stable(err_en))
        else $error("error enables changed with no update");

endmodule

bind dma_chan_gate dma_chan_gate_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .req_set_vld (req_set_vld),
    .req_set_ch  (req_set_ch),
    .req_clr_vld (req_clr_vld),
    .req_clr_ch  (req_clr_ch),
    .err_set_vld (err_set_vld),
    .err_set_ch  (err_set_ch),
    .err_clr_vld (err_clr_vld),
    .err_clr_ch  (err_clr_ch),
    .done_vld    (done_vld),
    .done_ch     (done_ch),
    .done_dis    (done_dis),
    .hw_req_i    (hw_req_i),
    .sw_req_i    (sw_req_i),
    .link_req_i  (link_req_i),
    .err_ind_i   (err_ind_i),
    .svc_req_o   (svc_req_o),
    .err_irq_o   (err_irq_o),
    .req_en      (req_en_q),
    .err_en      (err_en_q)
);

// File: tb/dma_chan_gate_tb_top.sv
`timescale 1ns/1ps
module dma_chan_gate_tb_top;

    localparam int N = 32;
    localparam logic [7:0] OFS_REQ = 8'h0C;
    localparam logic [7:0] OFS_ERR = 8'h10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         req_set_vld = 1'b0, req_clr_vld = 1'b0;
    logic [4:0]   req_set_ch = '0, req_clr_ch = '0;
    logic         err_set_vld = 1'b0, err_clr_vld = 1'b0;
    logic [4:0]   err_set_ch = '0, err_clr_ch = '0;
    logic         done_vld = 1'b0, done_dis = 1'b0;
    logic [4:0]   done_ch = '0;
    logic [N-1:0] hw_req_i = '0, sw_req_i = '0, link_req_i = '0, err_ind_i = '0;
    logic [N-1:0] svc_req_o, err_irq_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    dma_chan_gate dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_set_vld(req_set_vld), .req_set_ch(req_set_ch),
        .req_clr_vld(req_clr_vld), .req_clr_ch(req_clr_ch),
        .err_set_vld(err_set_vld), .err_set_ch(err_set_ch),
        .err_clr_vld(err_clr_vld), .err_clr_ch(err_clr_ch),
        .done_vld(done_vld), .done_ch(done_ch), .done_dis(done_dis),
        .hw_req_i(hw_req_i), .sw_req_i(sw_req_i), .link_req_i(link_req_i),
        .err_ind_i(err_ind_i), .svc_req_o(svc_req_o), .err_irq_o(err_irq_o)
    );

    // Expected enables, indexed by channel
    logic [N-1:0] exp_req = '0;
    logic [N-1:0] exp_err = '0;

    function automatic logic [N-1:0] rev(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int b = 0; b < N; b++) r[b] = v[N-1-b];
        return r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: inputs were driven at a falling edge, results are sampled at the next one
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 1'b0; req_set_vld = 1'b0; req_clr_vld = 1'b0;
        err_set_vld = 1'b0; err_clr_vld = 1'b0; done_vld = 1'b0; done_dis = 1'b0;
    endtask

    task automatic word_write(input logic [7:0] ofs, input logic [N-1:0] w);
        bus_wr = 1'b1; bus_addr = ofs; bus_wdata = w;
        tick();
        idle();
    endtask

    task automatic check_reads(input string tag);
        bus_addr = OFS_REQ; #1;
        check({tag, " req word"}, bus_rdata, rev(exp_req));
        bus_addr = OFS_ERR; #1;
        check({tag, " err word"}, bus_rdata, rev(exp_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pats [6];
        pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h1234_8765; pats[5] = 32'h0F0F_00F0;

        repeat (3) @(negedge clk);
        // R1: reset values, with every input line high
        hw_req_i = '1; err_ind_i = '1; #1;
        check("R1 svc during reset", svc_req_o, '0);
        check("R1 irq during reset", err_irq_o, '0);
        rst_n = 1'b1;
        tick();
        check_reads("R1");
        check("R1 svc after reset", svc_req_o, '0);
        check("R1 irq after reset", err_irq_o, '0);
        bus_addr = 8'h00; #1;
        check("R2 unmapped read", bus_rdata, '0);

        // R2: full-word writes, bit i of the word holds channel N-1-i
        foreach (pats[k]) begin
            word_write(OFS_REQ, pats[k]); exp_req = rev(pats[k]);
            word_write(OFS_ERR, ~pats[k]); exp_err = rev(~pats[k]);
            check_reads("R2");
            check("R2 svc from word", svc_req_o, exp_req);
            check("R8 irq from word", err_irq_o, exp_err);
            bus_addr = 8'h14; #1;
            check("R2 unmapped read", bus_rdata, '0);
        end

        // R5, R6: single-channel sets, one channel at a time, then clears
        word_write(OFS_REQ, '0); exp_req = '0;
        word_write(OFS_ERR, '0); exp_err = '0;
        for (int c = 0; c < N; c++) begin
            req_set_vld = 1'b1; req_set_ch = 5'(c);
            err_set_vld = 1'b1; err_set_ch = 5'(N-1-c);
            tick(); idle();
            exp_req[c] = 1'b1; exp_err[N-1-c] = 1'b1;
            check_reads("R5 R6 set");
        end
        for (int c = 0; c < N; c++) begin
            req_clr_vld = 1'b1; req_clr_ch = 5'(c);
            err_clr_vld = 1'b1; err_clr_ch = 5'(c);
            tick(); idle();
            exp_req[c] = 1'b0; exp_err[c] = 1'b0;
            check_reads("R5 R6 clear");
            check("R5 svc after clear", svc_req_o, exp_req);
            check("R6 irq after clear", err_irq_o, exp_err);
        end

        // R3, R8: combinational gating against an enable pattern
        word_write(OFS_REQ, 32'hC3C3_0FF0); exp_req = rev(32'hC3C3_0FF0);
        word_write(OFS_ERR, 32'h5555_AAAA); exp_err = rev(32'h5555_AAAA);
        foreach (pats[k]) begin
            hw_req_i = pats[k]; err_ind_i = ~pats[k] ^ 32'h0F0F_F0F0; #1;
            check("R3 hw gating", svc_req_o, pats[k] & exp_req);
            check("R8 irq gating", err_irq_o, err_ind_i & exp_err);
        end

        // R4: software and linked requests bypass the enable
        word_write(OFS_REQ, '0); exp_req = '0;
        hw_req_i = '1;
        foreach (pats[k]) begin
            sw_req_i = pats[k]; link_req_i = '0; #1;
            check("R4 sw bypass", svc_req_o, pats[k]);
            sw_req_i = '0; link_req_i = ~pats[k]; #1;
            check("R4 link bypass", svc_req_o, ~pats[k]);
        end
        sw_req_i = '0; link_req_i = '0; hw_req_i = '0;

        // R7: done events across every channel
        word_write(OFS_REQ, '1); exp_req = '1;
        for (int c = 0; c < N; c++) begin
            done_vld = 1'b1; done_ch = 5'(c); done_dis = 1'b0;
            tick(); idle();
            check_reads("R7 flag low");
            done_vld = 1'b1; done_ch = 5'(c); done_dis = 1'b1;
            tick(); idle();
            exp_req[c] = 1'b0;
            check_reads("R7 flag high");
        end

        // R9: priority on one bit
        word_write(OFS_REQ, '0); exp_req = '0;
        bus_wr = 1'b1; bus_addr = OFS_REQ; bus_wdata = '1;
        req_clr_vld = 1'b1; req_clr_ch = 5'd7;
        tick(); idle(); exp_req = '1; exp_req[7] = 1'b0;
        check_reads("R9 clear over word");
        bus_wr = 1'b1; bus_addr = OFS_REQ; bus_wdata = '0;
        req_set_vld = 1'b1; req_set_ch = 5'd20;
        tick(); idle(); exp_req = '0; exp_req[20] = 1'b1;
        check_reads("R9 set over word");
        req_set_vld = 1'b1; req_set_ch = 5'd20; req_clr_vld = 1'b1; req_clr_ch = 5'd20;
        tick(); idle(); exp_req[20] = 1'b0;
        check_reads("R9 clear over set");
        req_set_vld = 1'b1; req_set_ch = 5'd3;
        done_vld = 1'b1; done_ch = 5'd3; done_dis = 1'b1;
        tick(); idle();
        check_reads("R9 done over set");
        req_set_vld = 1'b1; req_set_ch = 5'd3;
        done_vld = 1'b1; done_ch = 5'd3; done_dis = 1'b0;
        tick(); idle(); exp_req[3] = 1'b1;
        check_reads("R9 set with flag low");
        bus_wr = 1'b1; bus_addr = OFS_ERR; bus_wdata = '0;
        err_set_vld = 1'b1; err_set_ch = 5'd31; err_clr_vld = 1'b1; err_clr_ch = 5'd30;
        tick(); idle(); exp_err = '0; exp_err[31] = 1'b1;
        check_reads("R9 err set over word");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule